// File: doc/BRIEF.md
# Queue Page Credit Checker

This block gates admission of outbound packets into four transmit queues: data (queue 0), command (queue 1), beacon (queue 2) and management (queue 3). Each queue draws buffer pages from a pool of its own and has a bounded number of packet slots. The block holds, for every queue, the number of free pages in its pool, the number of slots in use and the slot capacity.

A request carries a queue number, a byte length and an update flag. The block works out how many pages the packet will consume. This is the rounded-up page count of the length plus a configured reserved byte offset, plus one page for metadata and one spare page. It then checks that cost against the selected pool and queue. One cycle later it returns a result code together with the page cost. An accepted request that has update set debits the pool and takes one slot.

A reload port overwrites every counter at once from an externally gathered status snapshot. It is used whenever fresh occupancy figures arrive.

Top module: `qcredit_gate`

## Requirements
- R1: The page cost reported on `rsp_pages` equals ceil((req_len + cfg_rsv_bytes) / 256) + 2, where the two extra pages are one metadata page and one spare page.
- R2: A request whose page cost exceeds the selected queue's free pool pages gets result code 1 (no room). A cost exactly equal to the free pages is accepted with code 0.
- R3: A request to a queue whose slot capacity minus slots in use is zero (or less) gets code 1 (no room), even when pool pages suffice.
- R4: An accepted request (code 0) with `req_update` high lowers that queue's free pages by the page cost and raises its slots in use by one in the same clock edge. With `req_update` low, no counter changes.
- R5: The four queues keep independent counters. A request to queue N touches only queue N's counters.
- R6: When req_len + cfg_rsv_bytes exceeds 16128, the result is code 2 (size error) whatever the queue state or queue number, and no counter changes. A sum of exactly 16128 is not a size error.
- R7: A queue number of 4 or more (with no size error) gets code 3 (invalid queue), and no counter changes.
- R8: With `ld_valid` high, every queue's free pages, slots in use and capacity take the snapshot values at that edge. If a request arrives in the same cycle, it is judged against the old counters and its update is discarded.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. After reset, all counters are zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rsv_bytes | input | 16 | Reserved byte offset added to every packet length |
| req_valid | input | 1 | Request strobe |
| req_qid | input | 3 | Target queue number (0 data, 1 command, 2 beacon, 3 management) |
| req_len | input | 14 | Packet length in bytes |
| req_update | input | 1 | Apply debit and slot take on acceptance |
| ld_valid | input | 1 | Load all counters from the snapshot |
| ld_pool_pages | input | 64 | Snapshot free pages, queue i at bits [16i+15:16i] |
| ld_q_used | input | 32 | Snapshot slots in use, queue i at bits [8i+7:8i] |
| ld_q_cap | input | 32 | Snapshot slot capacity, queue i at bits [8i+7:8i] |
| rsp_valid | output | 1 | Result present |
| rsp_code | output | 2 | 0 accept, 1 no room, 2 size error, 3 invalid queue |
| rsp_pages | output | 11 | Page cost of the request answered |
| pool_free_o | output | 64 | Current free pages per queue, same packing as the snapshot |
| q_used_o | output | 32 | Current slots in use per queue, same packing as the snapshot |

## Verification
The bench goes after the off-by-one edges of the page arithmetic. Lengths landing exactly on a page multiple, or one byte past it, would expose a truncating divide or a missing spare page as a cost one lower than expected. Pool pages equal to the cost and one below it separate a strict from a non-strict comparison. A full queue with plenty of pages catches a design that ignores slots. It also drives sums of exactly 16128 and 16129 against out-of-range queue numbers, which shows a wrong error priority as the wrong code. A reload in the same cycle as an updating request exposes a design that applies the debit on top of the snapshot, because the reported counters would then sit below the loaded values.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_NOROOM = 2'd1,
        RSP_TOOBIG = 2'd2,
        RSP_BADQ   = 2'd3
    } rsp_code_e;

    localparam int META_PAGES  = 1;
    localparam int SPARE_PAGES = 1;
    localparam int FIXED_PAGES = META_PAGES + SPARE_PAGES;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qcc_cost.sv
module qcc_cost
    import qcc_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int RSV_W     = 16,
    parameter int PAGE_SH   = 8,
    parameter int MAX_BYTES = 16128,
    parameter int SUM_W     = max_i(LEN_W, RSV_W) + 1,
    parameter int PG_W      = SUM_W - PAGE_SH + 2
) (
    input  logic [LEN_W-1:0] len,
    input  logic [RSV_W-1:0] rsv,
    output logic [PG_W-1:0]  pages,
    output logic             too_big
);
    logic [SUM_W-1:0] total;
    logic             partial;

    always_comb begin
        total   = SUM_W'(len) + SUM_W'(rsv);
        partial = |total[PAGE_SH-1:0];
        pages   = PG_W'(total >> PAGE_SH) + PG_W'(partial) + PG_W'(FIXED_PAGES);
        too_big = (total > SUM_W'(MAX_BYTES));
    end
endmodule

// File: rtl/qcc_bank.sv
module qcc_bank #(
    parameter int POOL_W = 16,
    parameter int CNT_W  = 8,
    parameter int PG_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [POOL_W-1:0] load_pool,
    input  logic [CNT_W-1:0]  load_used,
    input  logic [CNT_W-1:0]  load_cap,
    input  logic              take,
    input  logic [PG_W-1:0]   cost,
    output logic [POOL_W-1:0] pool,
    output logic [CNT_W-1:0]  used,
    output logic [CNT_W-1:0]  cap
);
    localparam int EXT_W = (POOL_W > PG_W) ? POOL_W : PG_W;

    logic [EXT_W-1:0] after_debit;

    always_comb after_debit = EXT_W'(pool) - EXT_W'(cost);

    always_ff @(posedge clk) begin
        if (rst) begin
            pool <= '0;
            used <= '0;
            cap  <= '0;
        end else if (load) begin
            pool <= load_pool;
            used <= load_used;
            cap  <= load_cap;
        end else if (take) begin
            pool <= after_debit[POOL_W-1:0];
            used <= used + CNT_W'(1);
        end
    end
endmodule

// File: rtl/qcc_decide.sv
module qcc_decide
    import qcc_pkg::*;
#(
    parameter int POOL_W = 16,
    parameter int CNT_W  = 8,
    parameter int PG_W   = 11
) (
    input  logic              too_big,
    input  logic              qid_ok,
    input  logic [PG_W-1:0]   cost,
    input  logic [POOL_W-1:0] pool,
    input  logic [CNT_W-1:0]  used,
    input  logic [CNT_W-1:0]  cap,
    output rsp_code_e         code
);
    localparam int EXT_W = (POOL_W > PG_W) ? POOL_W : PG_W;

    logic pages_ok;
    logic slot_ok;

    always_comb begin
        pages_ok = EXT_W'(cost) <= EXT_W'(pool);
        slot_ok  = cap > used;
        if (too_big)
            code = RSP_TOOBIG;
        else if (!qid_ok)
            code = RSP_BADQ;
        else if (pages_ok && slot_ok)
            code = RSP_OK;
        else
            code = RSP_NOROOM;
    end
endmodule

// File: rtl/qcredit_gate.sv
module qcredit_gate
    import qcc_pkg::*;
#(
    parameter int NUM_Q     = 4,
    parameter int QID_W     = 3,
    parameter int LEN_W     = 14,
    parameter int RSV_W     = 16,
    parameter int POOL_W    = 16,
    parameter int CNT_W     = 8,
    parameter int PAGE_SH   = 8,
    parameter int MAX_BYTES = 16128,
    parameter int SUM_W     = max_i(LEN_W, RSV_W) + 1,
    parameter int PG_W      = SUM_W - PAGE_SH + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [RSV_W-1:0]        cfg_rsv_bytes,
    input  logic                    req_valid,
    input  logic [QID_W-1:0]        req_qid,
    input  logic [LEN_W-1:0]        req_len,
    input  logic                    req_update,
    input  logic                    ld_valid,
    input  logic [NUM_Q*POOL_W-1:0] ld_pool_pages,
    input  logic [NUM_Q*CNT_W-1:0]  ld_q_used,
    input  logic [NUM_Q*CNT_W-1:0]  ld_q_cap,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_code,
    output logic [PG_W-1:0]         rsp_pages,
    output logic [NUM_Q*POOL_W-1:0] pool_free_o,
    output logic [NUM_Q*CNT_W-1:0]  q_used_o
);
    logic [PG_W-1:0]   cost;
    logic              too_big;
    logic              qid_ok;
    logic [POOL_W-1:0] pool_a [NUM_Q];
    logic [CNT_W-1:0]  used_a [NUM_Q];
    logic [CNT_W-1:0]  cap_a  [NUM_Q];
    logic [POOL_W-1:0] sel_pool;
    logic [CNT_W-1:0]  sel_used;
    logic [CNT_W-1:0]  sel_cap;
    rsp_code_e         code;
    logic              commit;

    qcc_cost #(
        .LEN_W(LEN_W), .RSV_W(RSV_W), .PAGE_SH(PAGE_SH),
        .MAX_BYTES(MAX_BYTES), .SUM_W(SUM_W), .PG_W(PG_W)
    ) cost_i (
        .len(req_len), .rsv(cfg_rsv_bytes), .pages(cost), .too_big(too_big)
    );

    always_comb begin
        qid_ok   = (32'(req_qid) < NUM_Q);
        sel_pool = '0;
        sel_used = '0;
        sel_cap  = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (32'(req_qid) == i) begin
                sel_pool = pool_a[i];
                sel_used = used_a[i];
                sel_cap  = cap_a[i];
            end
        end
    end

    qcc_decide #(.POOL_W(POOL_W), .CNT_W(CNT_W), .PG_W(PG_W)) decide_i (
        .too_big(too_big), .qid_ok(qid_ok), .cost(cost),
        .pool(sel_pool), .used(sel_used), .cap(sel_cap), .code(code)
    );

    always_comb commit = req_valid && req_update && !ld_valid && (code == RSP_OK);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_bank
        logic take_g;
        always_comb take_g = commit && (32'(req_qid) == g);

        qcc_bank #(.POOL_W(POOL_W), .CNT_W(CNT_W), .PG_W(PG_W)) bank_i (
            .clk(clk), .rst(rst), .load(ld_valid),
            .load_pool(ld_pool_pages[g*POOL_W +: POOL_W]),
            .load_used(ld_q_used[g*CNT_W +: CNT_W]),
            .load_cap(ld_q_cap[g*CNT_W +: CNT_W]),
            .take(take_g), .cost(cost),
            .pool(pool_a[g]), .used(used_a[g]), .cap(cap_a[g])
        );

        always_comb begin
            pool_free_o[g*POOL_W +: POOL_W] = pool_a[g];
            q_used_o[g*CNT_W +: CNT_W]      = used_a[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
            rsp_pages <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_code  <= code;
                rsp_pages <= cost;
            end
        end
    end
endmodule

// File: rtl/qcc_checker.sv
module qcc_checker #(
    parameter int NUM_Q  = 4,
    parameter int QID_W  = 3,
    parameter int POOL_W = 16,
    parameter int CNT_W  = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic [QID_W-1:0]        req_qid,
    input logic                    req_update,
    input logic                    ld_valid,
    input logic [NUM_Q*POOL_W-1:0] ld_pool_pages,
    input logic [NUM_Q*CNT_W-1:0]  ld_q_used,
    input logic                    rsp_valid,
    input logic [1:0]              rsp_code,
    input logic [NUM_Q*POOL_W-1:0] pool_free_o,
    input logic [NUM_Q*CNT_W-1:0]  q_used_o
);
    // R9: response strobe follows request strobe by one cycle
    assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8: snapshot lands in the counters regardless of a concurrent request
    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> (pool_free_o == $past(ld_pool_pages)) && (q_used_o == $past(ld_q_used)));

    // R7: an invalid queue number never moves a counter
    assert_badq_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (32'(req_qid) >= NUM_Q) && !ld_valid)
        |=> $stable(pool_free_o) && $stable(q_used_o) && (rsp_code != 2'd0));

    // R4: without an updating request or reload the counters hold
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_update) && !ld_valid |=> $stable(pool_free_o) && $stable(q_used_o));

    // R4: a rejected updating request leaves the counters alone
    assert_reject_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_update && !ld_valid)
        |=> (rsp_code == 2'd0) || ($stable(pool_free_o) && $stable(q_used_o)));
endmodule

bind qcredit_gate qcc_checker #(
    .NUM_Q(NUM_Q), .QID_W(QID_W), .POOL_W(POOL_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_qid(req_qid),
    .req_update(req_update), .ld_valid(ld_valid), .ld_pool_pages(ld_pool_pages),
    .ld_q_used(ld_q_used), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .pool_free_o(pool_free_o), .q_used_o(q_used_o)
);

// File: tb/qcredit_gate_tb_top.sv
module qcredit_gate_tb_top;
    localparam int NQ = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_rsv_bytes;
    logic        req_valid;
    logic [2:0]  req_qid;
    logic [13:0] req_len;
    logic        req_update;
    logic        ld_valid;
    logic [63:0] ld_pool_pages;
    logic [31:0] ld_q_used;
    logic [31:0] ld_q_cap;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [10:0] rsp_pages;
    logic [63:0] pool_free_o;
    logic [31:0] q_used_o;

    int vectors = 0;
    int fails   = 0;
    int m_pool [NQ];
    int m_used [NQ];
    int m_cap  [NQ];

    always #5 clk = ~clk;

    qcredit_gate dut_i (
        .clk(clk), .rst(rst), .cfg_rsv_bytes(cfg_rsv_bytes),
        .req_valid(req_valid), .req_qid(req_qid), .req_len(req_len),
        .req_update(req_update), .ld_valid(ld_valid),
        .ld_pool_pages(ld_pool_pages), .ld_q_used(ld_q_used), .ld_q_cap(ld_q_cap),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pages(rsp_pages),
        .pool_free_o(pool_free_o), .q_used_o(q_used_o)
    );

    function automatic int exp_pages(input int len, input int rsv);
        return (len + rsv + 255) / 256 + 2;
    endfunction

    function automatic int exp_code(input int qid, input int len, input int rsv);
        if (len + rsv > 16128) return 2;
        if (qid >= NQ) return 3;
        if (exp_pages(len, rsv) > m_pool[qid]) return 1;
        if (m_cap[qid] - m_used[qid] <= 0) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_counters(input string tag);
        for (int q = 0; q < NQ; q++) begin
            check(int'(pool_free_o[q*16 +: 16]) == m_pool[q], {tag, " pool"},
                  int'(pool_free_o[q*16 +: 16]), m_pool[q]);
            check(int'(q_used_o[q*8 +: 8]) == m_used[q], {tag, " used"},
                  int'(q_used_o[q*8 +: 8]), m_used[q]);
        end
    endtask

    // Optional concurrent reload with the given snapshot arrays
    task automatic request(input int qid, input int len, input bit upd, input string tag,
                           input bit with_ld = 1'b0);
        int ec, ep;
        ec = exp_code(qid, len, int'(cfg_rsv_bytes));
        ep = exp_pages(len, int'(cfg_rsv_bytes));
        @(negedge clk);
        req_valid  = 1'b1;
        req_qid    = 3'(qid);
        req_len    = 14'(len);
        req_update = upd;
        ld_valid   = with_ld;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        ld_valid  = 1'b0;
        if (with_ld) begin
            for (int q = 0; q < NQ; q++) begin
                m_pool[q] = int'(ld_pool_pages[q*16 +: 16]);
                m_used[q] = int'(ld_q_used[q*8 +: 8]);
                m_cap[q]  = int'(ld_q_cap[q*8 +: 8]);
            end
        end else if (ec == 0 && upd) begin
            m_pool[qid] -= ep;
            m_used[qid] += 1;
        end
        check(rsp_valid == 1'b1, {tag, " R9 valid"}, int'(rsp_valid), 1);
        check(int'(rsp_code) == ec, {tag, " code"}, int'(rsp_code), ec);
        check(int'(rsp_pages) == ep, {tag, " R1 pages"}, int'(rsp_pages), ep);
        check_counters(tag);
    endtask

    task automatic set_snapshot(input int p0, input int p1, input int p2, input int p3,
                                input int u, input int c);
        ld_pool_pages = {16'(p3), 16'(p2), 16'(p1), 16'(p0)};
        ld_q_used     = {4{8'(u)}};
        ld_q_cap      = {4{8'(c)}};
    endtask

    task automatic reload();
        @(negedge clk);
        ld_valid = 1'b1;
        @(posedge clk);
        #1;
        ld_valid = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            m_pool[q] = int'(ld_pool_pages[q*16 +: 16]);
            m_used[q] = int'(ld_q_used[q*8 +: 8]);
            m_cap[q]  = int'(ld_q_cap[q*8 +: 8]);
        end
        check_counters("R8 reload");
        check(rsp_valid == 1'b0, "R9 no request", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 0; req_qid = 0; req_len = 0; req_update = 0;
        ld_valid = 0; cfg_rsv_bytes = 16'd0;
        set_snapshot(0, 0, 0, 0, 0, 0);
        for (int q = 0; q < NQ; q++) begin m_pool[q] = 0; m_used[q] = 0; m_cap[q] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R9 reset valid", int'(rsp_valid), 0);
        check_counters("R9 reset");
        @(negedge clk);
        rst = 1'b0;

        // R1: page arithmetic on page edges, no reserved offset
        set_snapshot(1000, 1000, 1000, 1000, 0, 200);
        reload();
        request(0, 0, 1'b0, "R1 len0");
        request(0, 1, 1'b0, "R1 len1");
        request(0, 256, 1'b0, "R1 len256");
        request(0, 257, 1'b0, "R1 len257");
        cfg_rsv_bytes = 16'd256;
        request(1, 256, 1'b0, "R1 rsv256");

        // R2: exact fit accepted, one page short rejected
        set_snapshot(5, 4, 100, 100, 0, 3);
        reload();
        request(0, 512, 1'b1, "R2 exact fit");
        request(1, 512, 1'b1, "R2 short");
        // R3: full queue with plenty of pages
        request(2, 10, 1'b1, "R3 take1");
        request(2, 10, 1'b1, "R3 take2");
        request(2, 10, 1'b1, "R3 take3");
        request(2, 10, 1'b1, "R3 full");
        // R4: no update leaves counters
        request(3, 100, 1'b0, "R4 no update");
        request(3, 100, 1'b1, "R4 update");
        // R6: size boundary, including precedence over invalid queue
        set_snapshot(500, 500, 500, 500, 0, 9);
        reload();
        request(0, 15872, 1'b1, "R6 at limit");
        request(1, 15873, 1'b1, "R6 over limit");
        request(7, 15873, 1'b1, "R6 over limit badq");
        // R7: invalid queues
        request(4, 10, 1'b1, "R7 q4");
        request(7, 10, 1'b1, "R7 q7");
        // R8: reload same cycle as an updating request
        set_snapshot(40, 41, 42, 43, 1, 5);
        request(1, 10, 1'b1, "R8 concurrent", 1'b1);
        // R5: independent queues
        request(0, 300, 1'b1, "R5 q0");
        request(3, 700, 1'b1, "R5 q3");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int qid, len, r;
            r = int'($urandom_range(0, 19));
            if (r == 0) begin
                set_snapshot(int'($urandom_range(0, 300)), int'($urandom_range(0, 300)),
                             int'($urandom_range(0, 300)), int'($urandom_range(0, 300)),
                             int'($urandom_range(0, 3)), int'($urandom_range(0, 8)));
                reload();
            end else if (r == 1) begin
                cfg_rsv_bytes = 16'($urandom_range(0, 512));
            end else begin
                qid = (r == 2) ? int'($urandom_range(4, 7)) : int'($urandom_range(0, 3));
                len = (r == 3) ? int'($urandom_range(15000, 16383)) : int'($urandom_range(0, 3000));
                request(qid, len, 1'($urandom_range(0, 1)), "R5 random");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule